// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side serial logic that answers the status-read command of a page-organised serial flash. The host lowers chip select, clocks in an eight-bit opcode on MOSI, and then keeps clocking. If the opcode is the status-read command, the block sends the eight-bit status byte on MISO, most significant bit first. It repeats the byte for as long as chip select stays low and the serial clock keeps toggling. Other opcodes get no reply.

The status byte is built from live inputs supplied by the rest of the device: the busy flag, the result of the most recent page compare, the sector-protection state and the page-size setting. A fixed four-bit density code fills the middle of the byte. The inputs are sampled again at the start of every byte, so a host that polls for ready sees the current state on each repetition. A status read may be started at any time, including while a self-timed operation is running.

The serial pins are oversampled by the block's own clock. SCK, CS_n and MOSI pass through a synchroniser, and the shifting is done on the detected SCK edges. MISO is given as a data bit plus an output enable for the pad. An enable of 0 means the pad is high-impedance.

Top module: `flash_status_responder`

## Requirements
- R1: With spi_cs_n low, MOSI is sampled on each SCK rising edge, MSB first. When the eight opcode bits equal 0xD7, the first status bit is driven on spi_miso after the SCK falling edge that follows the eighth opcode bit. It is valid at the next SCK rising edge.
- R2: The status byte is sent MSB first, one bit per SCK falling edge. After 8 bits it starts again from bit 7 for as long as spi_cs_n stays low. spi_miso changes only after a detected SCK falling edge.
- R3: The status inputs are captured when bit 7 of each byte is driven. A change in the middle of a byte does not alter the rest of that byte, and it appears in the next byte.
- R4: Bit 7 is 1 when dev_busy is 0 (ready) and 0 when dev_busy is 1. It can be read while busy.
- R5: Bit 6 equals cmp_mismatch: 0 means the last compare matched, 1 means at least one bit differed.
- R6: Bits 5 down to 2 always carry the density code 0101.
- R7: Bit 1 equals prot_on: 1 means sector protection is enabled.
- R8: Bit 0 equals page_pow2: 1 selects 256-byte pages, 0 selects 264-byte pages.
- R9: Any opcode other than 0xD7 is ignored. spi_miso_oe stays 0 until spi_cs_n goes high, however many SCK cycles follow.
- R10: spi_cs_n going high clears spi_miso_oe within 4 clk cycles and resets the opcode bit counter and decoder. A transaction cut short part-way through an opcode has no effect on the next one.
- R11: While rst_n is low at a clk edge, spi_miso_oe and spi_miso are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host |
| spi_miso_oe | output | 1 | MISO pad enable; 0 means high-impedance |
| dev_busy | input | 1 | 1 while a self-timed operation runs |
| cmp_mismatch | input | 1 | Result of the last page compare, 1 when it differed |
| prot_on | input | 1 | 1 when sector protection is enabled |
| page_pow2 | input | 1 | 1 for 256-byte pages, 0 for 264-byte pages |

## Verification
The assertions check the following on every cycle:
- the enable drops after chip select is released;
- the enable rises only once the decoder has accepted the status opcode;
- MISO moves only after a detected falling SCK edge;
- the first bit of a stream is the inverted busy flag.

Only the bench scenarios can show the other behaviours:
- the full bit order and field values across many status patterns;
- the snapshot at each byte boundary, tested with mid-byte input changes;
- rejection of wrong opcodes that differ in the first and the last bit;
- recovery after an opcode cut short by chip select.

// File: rtl/fsr_pkg.sv
// Package: shared constants, decoder states and the status byte layout
// for the serial flash status responder.
package fsr_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [1:0] {
        RX_OPCODE = 2'd0,
        RX_STREAM = 2'd1,
        RX_IGNORE = 2'd2
    } rx_state_e;

    // Lays out the status byte: ready, compare result, density, protection, page size.
    function automatic logic [STAT_W-1:0] pack_status(
        input logic       busy,
        input logic       mismatch,
        input logic [3:0] density,
        input logic       prot,
        input logic       pow2
    );
        return {~busy, mismatch, density, prot, pow2};
    endfunction

endpackage

// File: rtl/fsr_pin_sync.sv
// Module: fsr_pin_sync
// Brings a vector of asynchronous pins into the clk domain through a
// chain of STAGES flip-flops per bit.
// Assumes: each pin is slow enough relative to clk that a latency of
// STAGES cycles is acceptable, and that bits need no mutual coherence.
module fsr_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage: capture the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Later stages: pass the value one flop further along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/fsr_edge_det.sv
// Module: fsr_edge_det
// Gives single-cycle rise and fall pulses for a synchronised level.
// Assumes: the level is already in the clk domain. RST_VAL matches the
// idle level of the pin, so reset makes no false edge.
module fsr_edge_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev;

    // Keep last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;

endmodule

// File: rtl/fsr_cmd_rx.sv
// Module: fsr_cmd_rx
// Shifts in the opcode on SCK rising edges and decides whether the
// transaction is a status read (stream) or anything else (ignore).
// Assumes: cs_act is synchronised. Releasing chip select returns the
// decoder to opcode reception with an empty bit counter.
module fsr_cmd_rx
    import fsr_pkg::*;
#(
    parameter int               OPC_W  = 8,
    parameter logic [OPC_W-1:0] OPCODE = 8'hD7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic sck_rise,
    input  logic mosi,
    output logic stream
);

    localparam int CNT_W = (OPC_W > 1) ? $clog2(OPC_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OPC_W - 1);

    rx_state_e        state;
    logic [OPC_W-2:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic [OPC_W-1:0] word_next;

    assign word_next = {shreg, mosi};

    // Opcode shifter, bit counter and decision state.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            state <= RX_OPCODE;
            shreg <= '0;
            cnt   <= '0;
        end else if (sck_rise && state == RX_OPCODE) begin
            shreg <= word_next[OPC_W-2:0];
            if (cnt == LAST_BIT) begin
                cnt   <= '0;
                state <= (word_next == OPCODE) ? RX_STREAM : RX_IGNORE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign stream = (state == RX_STREAM);

endmodule

// File: rtl/fsr_stat_tx.sv
// Module: fsr_stat_tx
// Drives the status byte on MISO, one bit per SCK falling edge, MSB
// first. It takes a fresh snapshot of the status at the start of every byte.
// Assumes: status_now is in the clk domain. stream stays high for the
// rest of the transaction once set.
module fsr_stat_tx #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              stream,
    input  logic              sck_fall,
    input  logic [STAT_W-1:0] status_now,
    output logic              miso,
    output logic              miso_oe
);

    localparam int IDX_W = (STAT_W > 1) ? $clog2(STAT_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STAT_W - 1);

    logic [STAT_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;

    // Output shifter: load a snapshot at bit 0, otherwise shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            idx     <= '0;
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else if (!cs_act) begin
            idx     <= '0;
            miso_oe <= 1'b0;
        end else if (stream && sck_fall) begin
            miso_oe <= 1'b1;
            if (idx == '0) begin
                miso  <= status_now[STAT_W-1];
                shreg <= status_now << 1;
            end else begin
                miso  <= shreg[STAT_W-1];
                shreg <= shreg << 1;
            end
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/flash_status_responder.sv
// Module: flash_status_responder (top)
// Device-side responder for the status-read command of a serial flash.
// It synchronises the serial pins, decodes the opcode and streams the live
// status byte for as long as chip select stays low.
// Assumes: SCK half-period exceeds SYNC_STAGES+2 clk cycles; status inputs
// are synchronous to clk.
module flash_status_responder #(
    parameter int         SYNC_STAGES  = 2,
    parameter int         OPC_W        = 8,
    parameter logic [7:0] STATUS_OPC   = 8'hD7,
    parameter logic [3:0] DENSITY_CODE = 4'b0101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic dev_busy,
    input  logic cmp_mismatch,
    input  logic prot_on,
    input  logic page_pow2
);

    import fsr_pkg::*;

    localparam int PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100; // {cs_n, sck, mosi}

    logic [PIN_W-1:0]  pins_s;
    logic              cs_act;
    logic              sck_rise;
    logic              sck_fall;
    logic              stream;
    logic [STAT_W-1:0] status_now;

    fsr_pin_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({spi_cs_n, spi_sck, spi_mosi}),
        .sync_out(pins_s)
    );

    assign cs_act = ~pins_s[2];

    fsr_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(pins_s[1]),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    fsr_cmd_rx #(
        .OPC_W (OPC_W),
        .OPCODE(STATUS_OPC[OPC_W-1:0])
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (cs_act),
        .sck_rise(sck_rise),
        .mosi    (pins_s[0]),
        .stream  (stream)
    );

    assign status_now = pack_status(dev_busy, cmp_mismatch, DENSITY_CODE,
                                    prot_on, page_pow2);

    fsr_stat_tx #(.STAT_W(STAT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .stream    (stream),
        .sck_fall  (sck_fall),
        .status_now(status_now),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

endmodule

// File: rtl/fsr_chk.sv
// Module: fsr_chk
// Property checker bound into flash_status_responder.
module fsr_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic sck_fall,
    input logic stream,
    input logic busy,
    input logic miso,
    input logic miso_oe
);

    // R10
    cs_release_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    // R9
    oe_needs_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(stream));

    // R2
    miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sck_fall));

    // R4
    first_bit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> (miso == !$past(busy)));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!miso_oe && !miso));

endmodule

bind flash_status_responder fsr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .sck_fall(sck_fall),
    .stream  (stream),
    .busy    (dev_busy),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe)
);

// File: tb/tb_flash_status_responder.sv
module tb_flash_status_responder;

    localparam int HALF = 8; // clk cycles per SCK half-period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic spi_miso_oe;
    logic dev_busy = 1'b0;
    logic cmp_mismatch = 1'b0;
    logic prot_on = 1'b0;
    logic page_pow2 = 1'b0;

    int checks = 0;
    int errors = 0;
    bit rd_active = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [7:0] exp_q [$];
    logic [7:0] mon_byte = '0;
    int mon_cnt = 0;
    bit oe_ok = 1'b1;
    logic [3:0] plan_st [0:7];

    always #2 clk = ~clk; // 250 MHz

    flash_status_responder dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .dev_busy(dev_busy), .cmp_mismatch(cmp_mismatch), .prot_on(prot_on),
        .page_pow2(page_pow2)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    // s = {busy, mismatch, prot, pow2}
    task automatic apply_status(input logic [3:0] s);
        {dev_busy, cmp_mismatch, prot_on, page_pow2} = s;
    endtask

    function automatic logic [7:0] expect_byte(input logic [3:0] s);
        return {~s[3], s[2], 4'b0101, s[1], s[0]};
    endfunction

    task automatic send_bit(input logic b);
        spi_mosi = b;
        half();
        spi_sck = 1'b1;
        half();
        spi_sck = 1'b0;
    endtask

    task automatic send_opcode(input logic [7:0] op);
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
    endtask

    task automatic release_cs();
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(spi_miso_oe == 1'b0, "R10", "oe after cs release", spi_miso_oe, 0);
        half();
    endtask

    // Driver: full status read of n bytes using plan_st, with mid-byte changes.
    task automatic status_read(input int n);
        spi_cs_n = 1'b0;
        half();
        apply_status(plan_st[0]);
        exp_q.push_back(expect_byte(plan_st[0]));
        send_opcode(8'hD7);
        rd_active = 1'b1;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 8; b++) begin
                half();
                spi_sck = 1'b1;
                half();
                if (b == 3) apply_status(~plan_st[k]); // R3: mid-byte change
                if (b == 7 && k < n - 1) begin
                    apply_status(plan_st[k+1]);
                    exp_q.push_back(expect_byte(plan_st[k+1]));
                end
                spi_sck = 1'b0;
            end
        end
        rd_active = 1'b0;
        release_cs();
    endtask

    // Monitor: rebuild each byte as the host sees it and compare.
    always @(posedge spi_sck) begin
        if (rd_active) begin
            mon_byte = {mon_byte[6:0], spi_miso};
            oe_ok = oe_ok & spi_miso_oe;
            mon_cnt++;
            if (mon_cnt == 8) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected byte", mon_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(mon_byte == e && oe_ok,
                          {cur_tag, " R2 R3 R4 R5 R6 R7 R8"}, "status byte",
                          {oe_ok, mon_byte}, {1'b1, e});
                end
                mon_cnt = 0;
                oe_ok = 1'b1;
            end
        end
    end

    task automatic ignored_opcode(input logic [7:0] op);
        spi_cs_n = 1'b0;
        half();
        send_opcode(op);
        for (int i = 0; i < 16; i++) begin
            half();
            spi_sck = 1'b1;
            check(spi_miso_oe == 1'b0, "R9", "oe during ignored opcode", spi_miso_oe, 0);
            half();
            spi_sck = 1'b0;
        end
        release_cs();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        check(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R11", "reset outputs",
              {spi_miso_oe, spi_miso}, 0);
        rst_n = 1'b1;
        half();

        // R1 R4 R5 R6 R7 R8: corner values, repeated bytes
        cur_tag = "R1";
        plan_st[0] = 4'b0000; plan_st[1] = 4'b1111; plan_st[2] = 4'b1010;
        status_read(3);

        // R4: busy while reading, more patterns
        cur_tag = "R4";
        plan_st[0] = 4'b0101; plan_st[1] = 4'b0011;
        plan_st[2] = 4'b1001; plan_st[3] = 4'b0110;
        status_read(4);

        // R9: wrong opcodes differing in the last and the first bit
        ignored_opcode(8'hD6);
        ignored_opcode(8'h57);

        // R10: opcode cut short, then a clean read
        spi_cs_n = 1'b0;
        half();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        release_cs();
        cur_tag = "R10";
        plan_st[0] = 4'b1100; plan_st[1] = 4'b0001;
        status_read(2);

        check(exp_q.size() == 0, "R2", "expected queue drained", exp_q.size(), 0);
        done = 1'b1;
        report();
    end

endmodule